// File: doc/BRIEF.md
# Dual-Port Mailbox Register File

This block gives two agents, a host side and a management-controller (BMC) side, a shared set of sixteen byte registers. Each agent reaches them through its own byte-wide register port with a write strobe, an address and a combinational read path. Either side can read or write every data register. Each side also has a small set of private control registers that decide how the other side's activity reaches it as an interrupt.

There are two ways to signal the other side. A side can ring a doorbell: it writes its control register with bit 0 set, and this latches a pending flag in bit 7 of the peer's control register. Alternatively, a side can arrange that any write by its peer to selected data registers latches a per-register pending bit. For that, it sets enable bits, and mask bits decide which of those pending bits drive its interrupt line. Both kinds of pending state are sticky, so the receiving side may poll instead of taking the interrupt. The top data register is the natural place for the BMC to post asynchronous status, with the host enabling a write interrupt on it.

The protocol meaning of the register contents and any bus bridging are outside this block.

Top module: `mbox_regfile`

## Requirements
- R1: While reset is low at a clock edge, every data register, control register, enable, mask and pending byte on both sides is cleared to 0 and both interrupt outputs are low from the next cycle.
- R2: A write to data register i (address 0x00 to 0x0F) from either port is readable at address i from both ports in the cycle after the write edge.
- R3: When both ports write the same data register in the same cycle, the BMC port's data is stored.
- R4: A write to a side's control register (address 0x10) with bit 0 set sets bit 7 of the peer's control register and raises the peer's interrupt in the next cycle; the writer's own control register is unchanged and bit 0 always reads 0.
- R5: A control-register bit 7 that is set stays set until its own side writes the control register with bit 7 set; writing 0 there, or any write from the peer, leaves it set, and a new doorbell in the same cycle as the clear keeps it set.
- R6: A write by one port to data register i sets pending bit i of the other side if that side's enable bit i is set (enable at 0x11 for registers 0 to 7 and 0x12 for 8 to 15, register n at bit n mod 8); with the enable bit clear, nothing is latched.
- R7: A set mask bit i (mask at 0x13 for registers 0 to 7, 0x14 for 8 to 15, same bit order) keeps pending bit i from the interrupt, while the pending bit still reads as set at 0x15 (registers 0 to 7) or 0x16 (registers 8 to 15).
- R8: Writing 1 to a pending bit at 0x15 or 0x16 clears it; a new write event for that register in the same cycle keeps it set.
- R9: A side's own write to a data register never sets that side's own pending bits.
- R10: Each side's enable, mask and pending bytes are private to that side, and addresses 0x17 to 0x1F read 0 and ignore writes.
- R11: Each interrupt output is high exactly when its doorbell bit 7 is set or any pending bit with a clear mask bit is set, and it rises only in a cycle following a write on either port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | 5 | Host register address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data for h_addr, combinational |
| h_irq | output | 1 | Interrupt toward the host |
| b_wr | input | 1 | BMC write strobe |
| b_addr | input | 5 | BMC register address |
| b_wdata | input | 8 | BMC write data |
| b_rdata | output | 8 | BMC read data for b_addr, combinational |
| b_irq | output | 1 | Interrupt toward the BMC |

## Verification
The interrupt paths are driven with three patterns: a doorbell ring, a peer data write to an enabled register, and a peer write to a register that is not enabled. Observing the pending bytes and interrupt lines shows whether an event latches, stays latched, or was never raised. The same cycle conflicts, where both ports write one register, a clear meets a new doorbell, or a pending clear meets a new write event, show whether the priority rules hold. Masked against unmasked pending bits separate the polled state from the interrupt line. Reads through the opposite port and through unused addresses show whether state leaks from one side's private registers to the other.

// File: rtl/mbox_pkg.sv
// Shared constants for the mailbox register file.
// Assumes a byte-oriented control layout where the doorbell ring bit is the
// lowest bit and the pending flag is the top bit of the control byte.
package mbox_pkg;
    localparam int MB_RING_BIT = 0;

    // Number of control bytes needed to cover nreg one-bit fields of width dw.
    function automatic int mb_bytes(input int nreg, input int dw);
        return (nreg + dw - 1) / dw;
    endfunction
endpackage

// File: rtl/mbox_data_bank.sv
// Shared data registers with two write ports.
// Does: stores NREG words of DW bits; the BMC port wins a same-register
// conflict. Reports one write strobe per register per port.
// Assumes: data registers occupy addresses 0..NREG-1 on both ports.
module mbox_data_bank #(
    parameter int NREG = 16,
    parameter int DW   = 8,
    parameter int AW   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               h_we,
    input  logic [AW-1:0]      h_addr,
    input  logic [DW-1:0]      h_wdata,
    input  logic               b_we,
    input  logic [AW-1:0]      b_addr,
    input  logic [DW-1:0]      b_wdata,
    output logic [NREG*DW-1:0] data_flat,
    output logic [NREG-1:0]    h_hit,
    output logic [NREG-1:0]    b_hit
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [DW-1:0] word_q;

        // Decode this register's write strobe for each port.
        assign h_hit[i] = h_we && (h_addr == AW'(i));
        assign b_hit[i] = b_we && (b_addr == AW'(i));

        // Store the word; the BMC port takes priority.
        always_ff @(posedge clk) begin
            if (!rst_n)        word_q <= '0;
            else if (b_hit[i]) word_q <= b_wdata;
            else if (h_hit[i]) word_q <= h_wdata;
        end

        assign data_flat[i*DW +: DW] = word_q;
    end
endmodule

// File: rtl/mbox_side_ctrl.sv
// Per-side interrupt control.
// Does: holds the side's doorbell pending flag, write-interrupt enables,
// masks and pending bits; produces the side's interrupt and ring pulse.
// Assumes: control block starts at address NREG; NREG is a multiple of DW.
module mbox_side_ctrl
    import mbox_pkg::*;
#(
    parameter int NREG = 16,
    parameter int DW   = 8,
    parameter int AW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic            peer_ring,
    input  logic [NREG-1:0] peer_hit,
    output logic            ring,
    output logic            irq,
    output logic [DW-1:0]   csr_rdata
);
    localparam int NBYTE  = mb_bytes(NREG, DW);
    localparam int PBIT   = DW - 1;
    localparam int A_CTRL = NREG;
    localparam int A_EN   = NREG + 1;
    localparam int A_MASK = A_EN + NBYTE;
    localparam int A_PEND = A_MASK + NBYTE;

    logic            db_q;
    logic [NREG-1:0] en_q;
    logic [NREG-1:0] mask_q;
    logic [NREG-1:0] pend_q;
    logic [NREG-1:0] pend_clr;
    logic            ctrl_wr;

    assign ctrl_wr = we && (addr == AW'(A_CTRL));
    assign ring    = ctrl_wr && wdata[MB_RING_BIT];

    // Doorbell pending: a peer ring sets it, an own write-1 to the top bit clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                        db_q <= 1'b0;
        else if (peer_ring)                db_q <= 1'b1;
        else if (ctrl_wr && wdata[PBIT])   db_q <= 1'b0;
    end

    for (genvar k = 0; k < NBYTE; k++) begin : g_byte
        // Byte-wide enable register for data registers k*DW..k*DW+DW-1.
        always_ff @(posedge clk) begin
            if (!rst_n)                                en_q[k*DW +: DW] <= '0;
            else if (we && addr == AW'(A_EN + k))      en_q[k*DW +: DW] <= wdata;
        end

        // Byte-wide mask register for the same data registers.
        always_ff @(posedge clk) begin
            if (!rst_n)                                mask_q[k*DW +: DW] <= '0;
            else if (we && addr == AW'(A_MASK + k))    mask_q[k*DW +: DW] <= wdata;
        end

        // Write-1-to-clear strobes for this pending byte.
        assign pend_clr[k*DW +: DW] = (we && addr == AW'(A_PEND + k)) ? wdata : '0;
    end

    // Pending bits: new enabled peer writes set, own write-1 clears; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~pend_clr) | (peer_hit & en_q);
    end

    // Interrupt: doorbell or any unmasked pending bit.
    assign irq = db_q || |(pend_q & ~mask_q);

    // Read mux for this side's control block; other addresses read 0.
    always_comb begin
        csr_rdata = '0;
        if (addr == AW'(A_CTRL)) csr_rdata[PBIT] = db_q;
        for (int k = 0; k < NBYTE; k++) begin
            if (addr == AW'(A_EN + k))   csr_rdata = en_q[k*DW +: DW];
            if (addr == AW'(A_MASK + k)) csr_rdata = mask_q[k*DW +: DW];
            if (addr == AW'(A_PEND + k)) csr_rdata = pend_q[k*DW +: DW];
        end
    end
endmodule

// File: rtl/mbox_rd_sel.sv
// Read-data selector for one port.
// Does: returns the addressed data register, otherwise the side's control read.
// Assumes: the control block returns 0 for addresses it does not decode.
module mbox_rd_sel #(
    parameter int NREG = 16,
    parameter int DW   = 8,
    parameter int AW   = 5
) (
    input  logic [AW-1:0]      addr,
    input  logic [NREG*DW-1:0] data_flat,
    input  logic [DW-1:0]      csr_rdata,
    output logic [DW-1:0]      rdata
);
    // Pick a data register when the address falls in the shared range.
    always_comb begin
        rdata = csr_rdata;
        for (int i = 0; i < NREG; i++) begin
            if (addr == AW'(i)) rdata = data_flat[i*DW +: DW];
        end
    end
endmodule

// File: rtl/mbox_regfile.sv
// Dual-port mailbox register file, top level.
// Does: joins the shared data bank with one interrupt control block per side
// and one read selector per side; each side's doorbell and data writes feed
// the other side's control block.
// Assumes: both ports share one clock; reads are combinational.
module mbox_regfile #(
    parameter int NREG = 16,
    parameter int DW   = 8,
    parameter int AW   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_wr,
    input  logic [AW-1:0] h_addr,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    output logic          h_irq,
    input  logic          b_wr,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          b_irq
);
    logic [NREG*DW-1:0] data_flat;
    logic [NREG-1:0]    h_hit;
    logic [NREG-1:0]    b_hit;
    logic               h_ring;
    logic               b_ring;
    logic [DW-1:0]      h_csr;
    logic [DW-1:0]      b_csr;

    mbox_data_bank #(.NREG(NREG), .DW(DW), .AW(AW)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .h_we(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
        .b_we(b_wr), .b_addr(b_addr), .b_wdata(b_wdata),
        .data_flat(data_flat), .h_hit(h_hit), .b_hit(b_hit)
    );

    mbox_side_ctrl #(.NREG(NREG), .DW(DW), .AW(AW)) u_host_ctl (
        .clk(clk), .rst_n(rst_n),
        .we(h_wr), .addr(h_addr), .wdata(h_wdata),
        .peer_ring(b_ring), .peer_hit(b_hit),
        .ring(h_ring), .irq(h_irq), .csr_rdata(h_csr)
    );

    mbox_side_ctrl #(.NREG(NREG), .DW(DW), .AW(AW)) u_bmc_ctl (
        .clk(clk), .rst_n(rst_n),
        .we(b_wr), .addr(b_addr), .wdata(b_wdata),
        .peer_ring(h_ring), .peer_hit(h_hit),
        .ring(b_ring), .irq(b_irq), .csr_rdata(b_csr)
    );

    mbox_rd_sel #(.NREG(NREG), .DW(DW), .AW(AW)) u_host_rd (
        .addr(h_addr), .data_flat(data_flat), .csr_rdata(h_csr), .rdata(h_rdata)
    );

    mbox_rd_sel #(.NREG(NREG), .DW(DW), .AW(AW)) u_bmc_rd (
        .addr(b_addr), .data_flat(data_flat), .csr_rdata(b_csr), .rdata(b_rdata)
    );
endmodule

// File: rtl/mbox_regfile_chk.sv
// Property checker for the mailbox register file, bound to the top module.
// Assumes: the control register sits at address NREG on both ports.
module mbox_regfile_chk #(
    parameter int NREG = 16,
    parameter int DW   = 8,
    parameter int AW   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               h_wr,
    input logic [AW-1:0]      h_addr,
    input logic [DW-1:0]      h_wdata,
    input logic               h_irq,
    input logic               b_wr,
    input logic [AW-1:0]      b_addr,
    input logic [DW-1:0]      b_wdata,
    input logic               b_irq,
    input logic [NREG*DW-1:0] data_flat
);
    localparam int A_CTRL = NREG;

    logic          clash_q;
    logic [AW-1:0] clash_idx_q;
    logic [DW-1:0] clash_val_q;

    // Remember a same-register write conflict for checking one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clash_q     <= 1'b0;
            clash_idx_q <= '0;
            clash_val_q <= '0;
        end else begin
            clash_q     <= h_wr && b_wr && (h_addr == b_addr) && (b_addr < AW'(NREG));
            clash_idx_q <= b_addr;
            clash_val_q <= b_wdata;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!h_irq && !b_irq)); // R1

    AST_BMC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clash_q |-> (data_flat[clash_idx_q*DW +: DW] == clash_val_q)); // R3

    AST_HOST_RING: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && h_addr == AW'(A_CTRL) && h_wdata[0]) |=> b_irq); // R4

    AST_BMC_RING: assert property (@(posedge clk) disable iff (!rst_n)
        (b_wr && b_addr == AW'(A_CTRL) && b_wdata[0]) |=> h_irq); // R4

    AST_BIRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (b_irq && !b_wr) |=> b_irq); // R5

    AST_HIRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (h_irq && !h_wr) |=> h_irq); // R5

    AST_BIRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_irq) |-> $past(h_wr || b_wr)); // R11

    AST_HIRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(h_irq) |-> $past(h_wr || b_wr)); // R11
endmodule

bind mbox_regfile mbox_regfile_chk #(.NREG(NREG), .DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_irq(h_irq),
    .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata), .b_irq(b_irq),
    .data_flat(data_flat)
);

// File: tb/mbox_regfile_test.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module mbox_regfile_test;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       h_wr = 1'b0;
    logic [4:0] h_addr = '0;
    logic [7:0] h_wdata = '0;
    logic [7:0] h_rdata;
    logic       h_irq;
    logic       b_wr = 1'b0;
    logic [4:0] b_addr = '0;
    logic [7:0] b_wdata = '0;
    logic [7:0] b_rdata;
    logic       b_irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mbox_regfile uut (
        .clk(clk), .rst_n(rst_n),
        .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq),
        .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq(b_irq)
    );

    // Row: [28] bmc side, [27] write, [26:22] addr, [21:14] wdata,
    //      [13:6] expected read, [5] exp h_irq, [4] exp b_irq, [3:0] requirement
    localparam int NV = 30;
    localparam logic [28:0] TBL [NV] = '{
        {1'b0,1'b1,5'h03,8'hA5,8'h00,1'b0,1'b0,4'd0},
        {1'b0,1'b0,5'h03,8'h00,8'hA5,1'b0,1'b0,4'd2},  // R2 host readback
        {1'b1,1'b0,5'h03,8'h00,8'hA5,1'b0,1'b0,4'd2},  // R2 visible to BMC
        {1'b1,1'b1,5'h0F,8'h5C,8'h00,1'b0,1'b0,4'd0},
        {1'b0,1'b0,5'h0F,8'h00,8'h5C,1'b0,1'b0,4'd2},  // R2 BMC write seen by host
        {1'b1,1'b1,5'h11,8'h08,8'h00,1'b0,1'b0,4'd0},  // BMC enables reg 3
        {1'b0,1'b1,5'h03,8'h11,8'h00,1'b0,1'b0,4'd0},
        {1'b1,1'b0,5'h15,8'h00,8'h08,1'b0,1'b1,4'd6},  // R6 pending bit 3
        {1'b0,1'b0,5'h15,8'h00,8'h00,1'b0,1'b1,4'd9},  // R9 no own pending
        {1'b1,1'b1,5'h15,8'h08,8'h00,1'b0,1'b0,4'd0},
        {1'b1,1'b0,5'h15,8'h00,8'h00,1'b0,1'b0,4'd8},  // R8 cleared
        {1'b0,1'b1,5'h10,8'h01,8'h00,1'b0,1'b0,4'd0},  // host rings
        {1'b1,1'b0,5'h10,8'h00,8'h80,1'b0,1'b1,4'd4},  // R4 peer bit 7
        {1'b0,1'b0,5'h10,8'h00,8'h00,1'b0,1'b1,4'd4},  // R4 own unchanged
        {1'b0,1'b1,5'h10,8'h80,8'h00,1'b0,1'b0,4'd0},  // peer attempts clear
        {1'b1,1'b0,5'h10,8'h00,8'h80,1'b0,1'b1,4'd5},  // R5 still set
        {1'b1,1'b1,5'h10,8'h00,8'h00,1'b0,1'b0,4'd0},  // owner writes 0
        {1'b1,1'b0,5'h10,8'h00,8'h80,1'b0,1'b1,4'd5},  // R5 still set
        {1'b1,1'b1,5'h10,8'h80,8'h00,1'b0,1'b0,4'd0},  // owner clears
        {1'b1,1'b0,5'h10,8'h00,8'h00,1'b0,1'b0,4'd5},  // R5 cleared
        {1'b0,1'b1,5'h12,8'h80,8'h00,1'b0,1'b0,4'd0},  // host enables reg 15
        {1'b0,1'b1,5'h14,8'h80,8'h00,1'b0,1'b0,4'd0},  // host masks reg 15
        {1'b1,1'b1,5'h0F,8'h77,8'h00,1'b0,1'b0,4'd0},
        {1'b0,1'b0,5'h16,8'h00,8'h80,1'b0,1'b0,4'd7},  // R7 pending but masked
        {1'b0,1'b0,5'h0F,8'h00,8'h77,1'b0,1'b0,4'd2},
        {1'b0,1'b1,5'h1A,8'hFF,8'h00,1'b0,1'b0,4'd0},  // unused address write
        {1'b0,1'b0,5'h1A,8'h00,8'h00,1'b0,1'b0,4'd10}, // R10 reads 0
        {1'b0,1'b0,5'h11,8'h00,8'h00,1'b0,1'b0,4'd10}, // R10 private enable
        {1'b0,1'b0,5'h13,8'h00,8'h00,1'b0,1'b0,4'd10}, // R10 mask lo untouched
        {1'b0,1'b0,5'h14,8'h00,8'h80,1'b0,1'b0,4'd10}  // R10 mask hi kept
    };

    // Record one check; print a FAIL line on mismatch.
    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write one register through one port.
    task automatic wr(input bit bmc, input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        if (bmc) begin b_wr = 1'b1; b_addr = a; b_wdata = d; end
        else     begin h_wr = 1'b1; h_addr = a; h_wdata = d; end
        @(posedge clk);
        #1;
        h_wr = 1'b0;
        b_wr = 1'b0;
    endtask

    // Write through both ports in the same cycle.
    task automatic wr2(input logic [4:0] ha, input logic [7:0] hd,
                       input logic [4:0] ba, input logic [7:0] bd);
        @(negedge clk);
        h_wr = 1'b1; h_addr = ha; h_wdata = hd;
        b_wr = 1'b1; b_addr = ba; b_wdata = bd;
        @(posedge clk);
        #1;
        h_wr = 1'b0;
        b_wr = 1'b0;
    endtask

    // Read one register away from the clock edge.
    task automatic rd(input bit bmc, input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        if (bmc) b_addr = a; else h_addr = a;
        #1;
        d = bmc ? b_rdata : h_rdata;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1: every address on both sides reads 0 after reset, irqs low.
        for (int a = 0; a < 32; a++) begin
            rd(1'b0, 5'(a), v); check("R1 host reset read", v, 8'h00);
            rd(1'b1, 5'(a), v); check("R1 bmc reset read", v, 8'h00);
        end
        check("R1 irqs after reset", {6'b0, h_irq, b_irq}, 8'h00);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            logic [28:0] row;
            string tag;
            row = TBL[i];
            if (row[27]) begin
                wr(row[28], row[26:22], row[21:14]);
            end else begin
                rd(row[28], row[26:22], v);
                tag = $sformatf("R%0d row %0d", row[3:0], i);
                check(tag, v, row[13:6]);
                check({tag, " irq"}, {6'b0, h_irq, b_irq}, {6'b0, row[5], row[4]});
            end
        end

        // R11 and R7: unmasking the latched bit raises the host interrupt.
        wr(1'b0, 5'h14, 8'h00);
        #1; check("R11 unmask raises h_irq", {7'b0, h_irq}, 8'h01);
        // R8: host clears its pending bit 15.
        wr(1'b0, 5'h16, 8'h80);
        #1; check("R8 clear drops h_irq", {7'b0, h_irq}, 8'h00);

        // R3: same-register conflict, BMC value stored.
        wr2(5'h05, 8'h11, 5'h05, 8'h22);
        rd(1'b0, 5'h05, v); check("R3 bmc wins", v, 8'h22);

        // R8: new event and clear in one cycle, pending stays.
        wr2(5'h03, 8'h33, 5'h15, 8'h08);
        rd(1'b1, 5'h15, v); check("R8 set beats clear", v, 8'h08);
        check("R8 b_irq held", {7'b0, b_irq}, 8'h01);
        wr(1'b1, 5'h15, 8'h08);

        // R5: clear and new doorbell in one cycle, bit 7 stays.
        wr2(5'h10, 8'h01, 5'h10, 8'h80);
        rd(1'b1, 5'h10, v); check("R5 ring beats clear", v, 8'h80);
        wr(1'b1, 5'h10, 8'h80);
        rd(1'b1, 5'h10, v); check("R5 cleared after race", v, 8'h00);

        // R6: with the enable cleared, a peer write latches nothing.
        wr(1'b1, 5'h11, 8'h00);
        wr(1'b0, 5'h03, 8'h44);
        rd(1'b1, 5'h15, v); check("R6 disabled no pending", v, 8'h00);
        check("R6 b_irq low", {7'b0, b_irq}, 8'h00);

        // R6: BMC status write to register 15 interrupts the host.
        wr(1'b1, 5'h0F, 8'h01);
        rd(1'b0, 5'h16, v); check("R6 reg15 pending", v, 8'h80);
        check("R6 reg15 h_irq", {7'b0, h_irq}, 8'h01);

        // R4: BMC doorbell toward host.
        wr(1'b1, 5'h10, 8'h01);
        rd(1'b0, 5'h10, v); check("R4 bmc ring host bit7", v, 8'h80);

        // R1: reset mid-run clears data and interrupts.
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1; rst_n = 1'b1;
        check("R1 irqs after mid reset", {6'b0, h_irq, b_irq}, 8'h00);
        rd(1'b0, 5'h0F, v); check("R1 data after mid reset", v, 8'h00);
        rd(1'b0, 5'h12, v); check("R1 enable after mid reset", v, 8'h00);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule